// File: doc/BRIEF.md
# Radix-4 Carry-Save Division Recurrence

This block runs the iterative core of a radix-4 digit-recurrence divider for normalized fractional mantissas. Both the dividend and the divisor lie in [1/2, 1). A single-cycle start pulse, accepted only while the block is idle, latches the two operands. The block then produces one signed quotient digit from {-2, -1, 0, 1, 2} per cycle. Digit-to-binary conversion is left to a downstream stage. After the last digit it reports whether the final partial remainder is negative or zero, which a rounding stage needs.

The partial remainder is held as a sum vector and a carry vector. Each step shifts both vectors left by two bits and adds a multiple of 0, ±d or ±2d in one carry-save stage. Negative multiples are formed by bitwise inversion plus a carry injected into the free low bit of the carry vector. The digit selection is retimed. The next digit is chosen from the adder outputs at the end of the current cycle and kept in a three-bit register, so selection never starts a cycle. An operand multiplexer switches once per division. In the load cycle the digit register is preset to +1 and the multiplexer passes the dividend, so the first write stores w[0] = x. In every later cycle it passes the negated divisor. The remainder sign/zero detector sees forced-zero inputs except during the final cycle.

The dividend enters scaled by 1/4, and the remainder has 2 guard bits below the mantissa plus a sign bit. One division with the default 53-bit mantissa takes one load cycle, 28 digit cycles and one cycle for the remainder flags.

Top module: `rdiv4_core`

## Requirements
- R1: While rst_ni is low, and after its release until a start is accepted, busy_o, q_vld_o and ready_o are 0.
- R2: start_i is accepted only when busy_o is 0. A start_i pulse with other operands while busy_o is 1 has no effect on the digits, flags or timing of the division in progress, and it produces no extra ready_o pulse.
- R3: busy_o stays 1 for exactly 30 cycles after the edge that accepts start_i. ready_o is then 1 for exactly one cycle, and busy_o is 0 in that cycle.
- R4: Each division presents exactly 28 digits, one per cycle in consecutive cycles, with q_vld_o high only while busy_o is high. The most significant digit comes first.
- R5: q_o is a 3-bit two's complement digit, and while q_vld_o is 1 its value lies in {-2, -1, 0, 1, 2}.
- R6: Take X and D as the integer mantissas and Q as the sum of q_k·4^(28-k) over the digits in order. Then W = X·4^28 − 4·Q·D is the final remainder in units of 2^-55, and it satisfies 3·|W| ≤ 8·D. The same bound holds for the remainder after every digit step.
- R7: The first digit follows the selection thresholds, scaled by 16, applied to the 7-bit estimate and the three divisor bits below the leading one. x = d = 1/2 gives 1, and x = 1 − 2^-53 with d = 1/2 gives 2.
- R8: rem_neg_o equals the sign of W and rem_zero_o equals (W = 0). Both update only at the edge that raises ready_o and hold until the next completion.
- R9: When X·4^28 is an exact multiple of 4·D (for example x = d), rem_zero_o is 1 at completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken when idle |
| x_i | input | MANT_W | Dividend mantissa, MSB is 1 |
| d_i | input | MANT_W | Divisor mantissa, MSB is 1 |
| busy_o | output | 1 | Division in progress |
| q_vld_o | output | 1 | q_o holds a valid digit |
| q_o | output | 3 | Signed quotient digit, two's complement |
| ready_o | output | 1 | One-cycle completion pulse |
| rem_neg_o | output | 1 | Final remainder is negative |
| rem_zero_o | output | 1 | Final remainder is zero |

## Verification
The checker checks the following on every cycle:
- the digit range;
- the single-cycle completion pulse and its distance from the accepted start;
- the digit count per division;
- that busy_o cannot drop early;
- that the flags stay stable between completions;
- the carry-save remainder against the ±2/3·d bound after each step.

Only the bench's scenarios can show that the digit string really divides x by d. This holds when the reconstructed remainder stays inside its bound with the operand pair that was started, which also exposes a start that was wrongly accepted mid-division. The same applies to the exact-quotient cases that must give a zero remainder, and to the first digits picked at the table corners.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;

  typedef logic signed [2:0] qdig_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_ITER,
    ST_ROUND
  } rdiv_st_e;

  // Thresholds are x16; row picked by divisor bits below the leading one.
  function automatic qdig_t qsel_lookup(input logic [2:0] dsel, input logic signed [6:0] est);
    logic signed [6:0] t_p2, t_p1, t_z, t_n1;
    qdig_t q;
    case (dsel)
      3'd0:    begin t_p2 = 7'sd12; t_p1 = 7'sd4; t_z = -7'sd4; t_n1 = -7'sd13; end
      3'd1:    begin t_p2 = 7'sd14; t_p1 = 7'sd4; t_z = -7'sd6; t_n1 = -7'sd15; end
      3'd2:    begin t_p2 = 7'sd15; t_p1 = 7'sd4; t_z = -7'sd6; t_n1 = -7'sd16; end
      3'd3:    begin t_p2 = 7'sd16; t_p1 = 7'sd4; t_z = -7'sd6; t_n1 = -7'sd18; end
      3'd4:    begin t_p2 = 7'sd18; t_p1 = 7'sd6; t_z = -7'sd8; t_n1 = -7'sd20; end
      3'd5:    begin t_p2 = 7'sd20; t_p1 = 7'sd6; t_z = -7'sd8; t_n1 = -7'sd20; end
      3'd6:    begin t_p2 = 7'sd20; t_p1 = 7'sd8; t_z = -7'sd8; t_n1 = -7'sd22; end
      default: begin t_p2 = 7'sd22; t_p1 = 7'sd8; t_z = -7'sd8; t_n1 = -7'sd24; end
    endcase
    if (est >= t_p2)      q = 3'sd2;
    else if (est >= t_p1) q = 3'sd1;
    else if (est >= t_z)  q = 3'sd0;
    else if (est >= t_n1) q = -3'sd1;
    else                  q = -3'sd2;
    return q;
  endfunction

endpackage

// File: rtl/rdiv_mult_gen.sv
module rdiv_mult_gen
  import rdiv_pkg::*;
#(
  parameter int unsigned RW = 56
) (
  input  qdig_t          q_i,
  input  logic [RW-1:0]  op_i,
  output logic [RW-1:0]  mult_o,
  output logic           cin_o
);
  logic [RW-1:0] op_x2;
  assign op_x2 = {op_i[RW-2:0], 1'b0};

  always_comb begin
    mult_o = '0;
    cin_o  = 1'b0;
    case (q_i)
      3'sd1:   mult_o = op_i;
      3'sd2:   mult_o = op_x2;
      -3'sd1:  begin mult_o = ~op_i;  cin_o = 1'b1; end
      -3'sd2:  begin mult_o = ~op_x2; cin_o = 1'b1; end
      default: mult_o = '0;
    endcase
  end
endmodule

// File: rtl/rdiv_csa.sv
module rdiv_csa #(
  parameter int unsigned RW = 56
) (
  input  logic [RW-1:0] a_i,
  input  logic [RW-1:0] b_i,
  input  logic [RW-1:0] c_i,
  input  logic          cin_i,
  output logic [RW-1:0] sum_o,
  output logic [RW-1:0] cy_o
);
  logic [RW-2:0] maj;

  assign sum_o = a_i ^ b_i ^ c_i;

  for (genvar i = 0; i < RW - 1; i++) begin : g_maj
    assign maj[i] = (a_i[i] & b_i[i]) | (a_i[i] & c_i[i]) | (b_i[i] & c_i[i]);
  end

  // low carry slot is free: it takes the two's complement increment
  assign cy_o = {maj, cin_i};
endmodule

// File: rtl/rdiv_qsel.sv
module rdiv_qsel
  import rdiv_pkg::*;
(
  input  logic [6:0] s_top_i,
  input  logic [6:0] c_top_i,
  input  logic [2:0] dsel_i,
  output qdig_t      q_o
);
  logic [6:0] est;
  assign est = s_top_i + c_top_i;
  assign q_o = qsel_lookup(dsel_i, signed'(est));
endmodule

// File: rtl/rdiv_szd.sv
module rdiv_szd #(
  parameter int unsigned RW = 56
) (
  input  logic          en_i,
  input  logic [RW-1:0] s_i,
  input  logic [RW-1:0] c_i,
  output logic          neg_o,
  output logic          zero_o
);
  logic [RW-1:0] s_g, c_g, rem;

  // inputs forced quiet outside the final step
  assign s_g    = en_i ? s_i : '0;
  assign c_g    = en_i ? c_i : '0;
  assign rem    = s_g + c_g;
  assign neg_o  = rem[RW-1];
  assign zero_o = (rem == '0);
endmodule

// File: rtl/rdiv4_core.sv
module rdiv4_core
  import rdiv_pkg::*;
#(
  parameter int unsigned MANT_W = 53
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [MANT_W-1:0] x_i,
  input  logic [MANT_W-1:0] d_i,
  output logic              busy_o,
  output logic              q_vld_o,
  output logic [2:0]        q_o,
  output logic              ready_o,
  output logic              rem_neg_o,
  output logic              rem_zero_o
);
  localparam int unsigned FRAC_W = MANT_W + 2;
  localparam int unsigned RW     = FRAC_W + 1;
  localparam int unsigned ITERS  = (FRAC_W + 1) / 2;
  localparam int unsigned CNT_W  = $clog2(ITERS + 1);

  rdiv_st_e          st_q;
  logic [RW-1:0]     ws_q, wc_q, xop_q, dneg_q;
  qdig_t             q_q, q_nxt;
  logic [2:0]        dsel_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              ready_q, neg_q, zero_q;

  logic              start_acc;
  logic [RW-1:0]     d_al, x_al, op, ws_sh, wc_sh, mult, s_nxt, c_nxt;
  logic              cin;
  logic              szd_neg, szd_zero;

  assign start_acc = start_i && (st_q == ST_IDLE);
  assign x_al      = {3'b000, x_i};
  assign d_al      = {1'b0, d_i, 2'b00};

  // operand switches once per division
  assign op    = (st_q == ST_LOAD) ? xop_q : dneg_q;
  assign ws_sh = {ws_q[RW-3:0], 2'b00};
  assign wc_sh = {wc_q[RW-3:0], 2'b00};

  rdiv_mult_gen #(.RW(RW)) u_mult (
    .q_i    (q_q),
    .op_i   (op),
    .mult_o (mult),
    .cin_o  (cin)
  );

  rdiv_csa #(.RW(RW)) u_csa (
    .a_i   (ws_sh),
    .b_i   (wc_sh),
    .c_i   (mult),
    .cin_i (cin),
    .sum_o (s_nxt),
    .cy_o  (c_nxt)
  );

  rdiv_qsel u_qsel (
    .s_top_i (s_nxt[RW-1 -: 7]),
    .c_top_i (c_nxt[RW-1 -: 7]),
    .dsel_i  (dsel_q),
    .q_o     (q_nxt)
  );

  rdiv_szd #(.RW(RW)) u_szd (
    .en_i   (st_q == ST_ROUND),
    .s_i    (ws_q),
    .c_i    (wc_q),
    .neg_o  (szd_neg),
    .zero_o (szd_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      ws_q    <= '0;
      wc_q    <= '0;
      xop_q   <= '0;
      dneg_q  <= '0;
      q_q     <= '0;
      dsel_q  <= '0;
      cnt_q   <= '0;
      ready_q <= 1'b0;
      neg_q   <= 1'b0;
      zero_q  <= 1'b0;
    end else begin
      ready_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (start_acc) begin
            xop_q  <= x_al;
            dneg_q <= -d_al;
            dsel_q <= d_i[MANT_W-2 -: 3];
            ws_q   <= '0;
            wc_q   <= '0;
            q_q    <= 3'sd1;
            st_q   <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          ws_q  <= s_nxt;
          wc_q  <= c_nxt;
          q_q   <= q_nxt;
          cnt_q <= '0;
          st_q  <= ST_ITER;
        end
        ST_ITER: begin
          ws_q  <= s_nxt;
          wc_q  <= c_nxt;
          q_q   <= q_nxt;  // last selection is dropped
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(ITERS - 1)) st_q <= ST_ROUND;
        end
        default: begin
          neg_q   <= szd_neg;
          zero_q  <= szd_zero;
          ready_q <= 1'b1;
          st_q    <= ST_IDLE;
        end
      endcase
    end
  end

  assign busy_o     = (st_q != ST_IDLE);
  assign q_vld_o    = (st_q == ST_ITER);
  assign q_o        = q_q;
  assign ready_o    = ready_q;
  assign rem_neg_o  = neg_q;
  assign rem_zero_o = zero_q;

endmodule

// File: rtl/rdiv4_core_chk.sv
module rdiv4_core_chk #(
  parameter int unsigned MANT_W = 53,
  parameter int unsigned RW     = MANT_W + 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          busy_o,
  input logic          q_vld_o,
  input logic [2:0]    q_o,
  input logic          ready_o,
  input logic          rem_neg_o,
  input logic          rem_zero_o,
  input logic [RW-1:0] ws_i,
  input logic [RW-1:0] wc_i,
  input logic [RW-1:0] dneg_i,
  input logic          wchk_i
);
  localparam int unsigned ITERS = (MANT_W + 3) / 2;
  localparam int unsigned LAT   = ITERS + 2;

  int unsigned cyc_q, dig_q;
  logic [RW-1:0] w_sum, w_abs, d_pos;
  logic [RW+2:0] lhs, rhs;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q <= 0;
      dig_q <= 0;
    end else if (start_i && !busy_o) begin
      cyc_q <= 0;
      dig_q <= 0;
    end else begin
      if (busy_o)  cyc_q <= cyc_q + 1;
      if (q_vld_o) dig_q <= dig_q + 1;
    end
  end

  assign w_sum = ws_i + wc_i;
  assign w_abs = w_sum[RW-1] ? -w_sum : w_sum;
  assign d_pos = -dneg_i;
  assign lhs   = {3'b000, w_abs} * 3;
  assign rhs   = {3'b000, d_pos} * 2;

  // R3
  ready_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);

  // R3
  ready_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (cyc_q == LAT && !busy_o));

  // R2
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cyc_q < LAT - 1) |=> busy_o);

  // R4
  dig_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> dig_q == ITERS);

  // R4
  vld_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_vld_o |-> busy_o);

  // R5
  q_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_vld_o |-> (q_o != 3'b011 && q_o != 3'b100));

  // R6
  w_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wchk_i |-> lhs <= rhs);

  // R8
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> $stable({rem_neg_o, rem_zero_o}));

endmodule

bind rdiv4_core rdiv4_core_chk #(.MANT_W(MANT_W), .RW(RW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .q_vld_o    (q_vld_o),
  .q_o        (q_o),
  .ready_o    (ready_o),
  .rem_neg_o  (rem_neg_o),
  .rem_zero_o (rem_zero_o),
  .ws_i       (ws_q),
  .wc_i       (wc_q),
  .dneg_i     (dneg_q),
  .wchk_i     (st_q == rdiv_pkg::ST_ITER || st_q == rdiv_pkg::ST_ROUND)
);

// File: tb/tb_rdiv4_core.sv
module tb_rdiv4_core;
  localparam int MW = 53;
  localparam int N  = (MW + 3) / 2;

  typedef struct {
    logic [MW-1:0] x;
    logic [MW-1:0] d;
    longint        t0;
    bit            has_first;
    int            first;
  } item_t;

  logic clk = 1'b0, rst_ni = 1'b0, start = 1'b0;
  logic [MW-1:0] x_in = '0, d_in = '0;
  logic busy, q_vld, ready, rem_neg, rem_zero;
  logic [2:0] q;

  int n_chk = 0, n_fail = 0;
  longint cyc = 0;
  item_t sb[$];

  rdiv4_core #(.MANT_W(MW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .x_i(x_in), .d_i(d_in),
    .busy_o(busy), .q_vld_o(q_vld), .q_o(q), .ready_o(ready),
    .rem_neg_o(rem_neg), .rem_zero_o(rem_zero)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string msg);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic run_div(input logic [MW-1:0] x, input logic [MW-1:0] d,
                         input bit has_first, input int first);
    item_t it;
    @(posedge clk); #1;
    while (busy) begin @(posedge clk); #1; end
    start = 1'b1; x_in = x; d_in = d;
    it.x = x; it.d = d; it.t0 = cyc; it.has_first = has_first; it.first = first;
    sb.push_back(it);
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  // monitor
  logic signed [127:0] acc = '0;
  int ndig = 0, first_dig = 0;
  bit prev_ready = 1'b0;

  always @(negedge clk) begin
    if (rst_ni) begin
      if (q_vld) begin
        // R5
        chk($signed(q) >= -2 && $signed(q) <= 2, "R5",
            $sformatf("digit %0d outside -2..2", $signed(q)));
        if (ndig == 0) first_dig = $signed(q);
        acc = acc * 4 + 128'($signed(q));
        ndig++;
      end
      if (ready) begin
        // R3
        chk(!prev_ready, "R3", "ready high 2 cycles, exp 1");
        if (sb.size() == 0) begin
          // R2
          chk(1'b0, "R2", "completion with no accepted start, exp none");
        end else begin
          item_t it;
          logic signed [127:0] xs, ds, w, w_abs;
          it = sb.pop_front();
          xs = 128'(it.x);
          ds = 128'(it.d);
          w  = (xs <<< (2 * N)) - 4 * acc * ds;
          w_abs = (w < 0) ? -w : w;
          // R3
          chk(cyc - it.t0 == 31, "R3",
              $sformatf("latency %0d exp 31", cyc - it.t0));
          // R4
          chk(ndig == N, "R4", $sformatf("digits %0d exp %0d", ndig, N));
          // R6 / R2: digits must divide the operands that were started
          chk(3 * w_abs <= 8 * ds, "R6",
              $sformatf("|W|=%0d exceeds bound 8D/3, D=%0d", w_abs, ds));
          // R8
          chk(rem_neg == (w < 0), "R8",
              $sformatf("rem_neg %0b exp %0b", rem_neg, (w < 0)));
          // R8 / R9
          chk(rem_zero == (((xs <<< (2 * N)) % (4 * ds)) == 0), "R9",
              $sformatf("rem_zero %0b exp %0b", rem_zero,
                        (((xs <<< (2 * N)) % (4 * ds)) == 0)));
          if (it.has_first) begin
            // R7
            chk(first_dig == it.first, "R7",
                $sformatf("first digit %0d exp %0d", first_dig, it.first));
          end
        end
        acc = '0;
        ndig = 0;
      end
      prev_ready = ready;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run hung, exp completion");
    summary();
    $finish;
  end

  localparam logic [MW-1:0] HALF = {1'b1, {(MW-1){1'b0}}};
  localparam logic [MW-1:0] ONES = '1;
  localparam logic [MW-1:0] TQ   = {2'b11, {(MW-2){1'b0}}};

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1
    chk(!busy && !q_vld && !ready, "R1",
        $sformatf("in reset busy=%0b vld=%0b ready=%0b exp 000", busy, q_vld, ready));
    rst_ni = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    // R1
    chk(!busy && !q_vld && !ready, "R1",
        $sformatf("after reset busy=%0b vld=%0b ready=%0b exp 000", busy, q_vld, ready));

    run_div(HALF, HALF, 1'b1, 1);   // R7, R9
    run_div(ONES, HALF, 1'b1, 2);   // R7
    run_div(HALF, ONES, 1'b0, 0);
    run_div(TQ, TQ, 1'b0, 0);       // R9 exact
    run_div(ONES, ONES, 1'b0, 0);   // R9 exact

    // R2: extra start while busy, different operands
    run_div(TQ, ONES, 1'b0, 0);
    repeat (5) @(posedge clk);
    #1;
    chk(busy, "R2", $sformatf("busy %0b exp 1 before ignored start", busy));
    start = 1'b1; x_in = HALF; d_in = HALF;
    @(posedge clk); #1;
    start = 1'b0;

    for (int i = 0; i < 8; i++) begin
      logic [63:0] rx, rd;
      rx = {$urandom(), $urandom()};
      rd = {$urandom(), $urandom()};
      run_div({1'b1, rx[MW-2:0]}, {1'b1, rd[MW-2:0]}, 1'b0, 0);
    end

    @(posedge clk); #1;
    while (busy || sb.size() != 0) begin @(posedge clk); #1; end
    repeat (3) @(posedge clk);
    #1;
    // R8: flags hold after completion
    chk(!ready && !busy, "R8", $sformatf("ready %0b busy %0b exp 0 0 when idle", ready, busy));
    summary();
    $finish;
  end
endmodule